// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block drives the fractional part of a clock synthesizer's feedback divider with a slowly varying signed offset. Sweeping the divider ratio this way spreads the synthesized clock over a narrow band, which lowers the peak energy of each harmonic and so reduces radiated emissions. A sigma-delta modulator downstream consumes the offset word. The analog loop and that modulator sit outside this block.

The sweep shape can be triangular, sine-like, or a steeper-ended cubic curve. The sweep is either symmetric about the nominal ratio (center spreading) or kept entirely at or below it (down spreading). The peak-to-peak excursion is set by a deviation word. The sweep repeats every 256 update steps, and an integer divider sets how many reference cycles each step lasts. Writes to the configuration take effect only when the sweep returns to its start, so the output frequency never jumps mid-sweep. A separate output gives the mean offset, so that the long-run average frequency can be centred. Dropping the enable forces a clean, unspread clock.

Top module: `ssm_profile_gen`

## Requirements
- R1: While rst_n is low at a clock edge, offset_out, mean_out and upd_tick are all zero after that edge.
- R2: While spread_en is low, offset_out and mean_out are exactly zero and upd_tick is low from the first edge after it falls, and the sweep restarts at phase 0 on the first edge with spread_en high.
- R3: The sweep phase is 8 bits (256 steps per period). It advances once every rate_div reference cycles, and a rate_div of 0 behaves as 1. upd_tick is high for exactly the one cycle in which offset_out first shows a new phase. The offset for phase 0 appears after the first enabled edge, and the first pulse follows rate_div cycles later.
- R4: Shape codes 0 and 3 select the triangle, with quarter magnitude Q(k) = min(512·k, 32767) for k = 0..64.
- R5: Shape code 1 selects the sine-like curve, with Q(k) = min(floor((12288·k − k³)/16), 32767).
- R6: Shape code 2 selects the steep-ended curve, with Q(k) = min(floor((4096·k + k³)/16), 32767).
- R7: With phase bits [7:6] as the quadrant q and bits [5:0] as k, the profile value p is +Q(k), +Q(64−k), −Q(k) and −Q(64−k) for q = 0, 1, 2 and 3.
- R8: Center mode (down_sel = 0) gives offset_out = floor(p·dev_cfg / 65536), a 16-bit two's-complement value bounded by ±dev_cfg/2.
- R9: Down mode (down_sel = 1) gives offset_out = floor((p − 32768)·dev_cfg / 65536), and this is never positive.
- R10: mean_out is 0 in center mode and −floor(dev_cfg/2) in down mode, using the configuration currently in effect.
- R11: While spread_en is high, changes to down_sel, shape_sel, dev_cfg and rate_div are adopted only at the edge where the phase wraps from 255 to 0. While spread_en is low, they are adopted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spread_en | input | 1 | High to sweep; low forces zero offset |
| down_sel | input | 1 | 1 = down spreading, 0 = center spreading |
| shape_sel | input | 2 | Profile shape code (0/3 triangle, 1 sine-like, 2 steep-ended) |
| dev_cfg | input | 15 | Peak-to-peak deviation in offset LSBs |
| rate_div | input | 16 | Reference cycles per sweep step |
| offset_out | output | 16 | Signed divider offset word |
| mean_out | output | 16 | Signed mean of the sweep for centring |
| upd_tick | output | 1 | Pulses in the first cycle of each new offset |

## Verification
The bench walks whole sweep periods for every shape and both spreading modes. This exposes quadrant mirroring that is off by one step, since the shape would then show a doubled or missing sample at the peaks. It also exposes a down-mode bias applied with the wrong sign, since the offset would turn positive. A rate_div of 0 and a deviation of 0 are applied to catch a divider that stalls or a scaler that leaks a nonzero value. A configuration written mid-sweep must not appear before the wrap, because a design that adopts it early would glitch the frequency inside the sweep. Dropping the enable mid-sweep must give zero offset at once and a restart from phase 0.

// File: rtl/ssm_pkg.sv
// Shared types and the elaboration-time curve function for the
// spread-spectrum profile generator. Assumes phase and value widths small
// enough that 64-bit intermediate arithmetic cannot overflow.
package ssm_pkg;

    typedef enum logic [1:0] {
        SHP_TRI     = 2'd0,
        SHP_SINE    = 2'd1,
        SHP_STEEP   = 2'd2,
        SHP_TRI_ALT = 2'd3
    } shape_e;

    localparam int SHAPE_COUNT = 3;

    // Quarter-wave magnitude for step k of qn, full scale fs, clamped to fs-1.
    function automatic longint quarter_val(input int shape, input longint k,
                                           input longint qn, input longint fs);
        longint v;
        case (shape)
            1:       v = (fs * (3 * k * qn * qn - k * k * k)) / (2 * qn * qn * qn);
            2:       v = (fs * (k * qn * qn + k * k * k)) / (2 * qn * qn * qn);
            default: v = (fs * k) / qn;
        endcase
        if (v > fs - 1) v = fs - 1;
        return v;
    endfunction

endpackage

// File: rtl/ssm_phase_gen.sv
// Step divider and sweep phase counter. Counts reference cycles up to
// div_val (0 treated as 1), then advances the phase by one. Assumes div_val
// changes only when the counter is at zero (guaranteed by the top's latch).
module ssm_phase_gen #(
    parameter int PH_W  = 8,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick,
    output logic             wrap,
    output logic [PH_W-1:0]  phase
);

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_last;

    // Last count value of one step; zero means every cycle is a step.
    always_comb begin
        div_last = (div_val == '0) ? '0 : div_val - DIV_W'(1);
    end

    assign tick = run && (div_cnt >= div_last);
    assign wrap = tick && (phase == {PH_W{1'b1}});

    // Advance the cycle counter and, at each step, the phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
            phase   <= '0;
        end else if (tick) begin
            div_cnt <= '0;
            phase   <= phase + PH_W'(1);
        end else begin
            div_cnt <= div_cnt + DIV_W'(1);
        end
    end

    // R3: each step moves the phase by exactly one.
    assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (phase == $past(phase) + PH_W'(1)));

    // R3: the cycle counter never passes the step length.
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (div_cnt <= div_last));

endmodule

// File: rtl/ssm_quarter_rom.sv
// One quarter-wave magnitude table, built at elaboration from the curve
// function. Input k runs 0..QN; k = QN returns the clamped full scale.
module ssm_quarter_rom #(
    parameter int SHAPE = 0,
    parameter int IDX_W = 6,
    parameter int VAL_W = 16
) (
    input  logic [IDX_W:0]   k,
    output logic [VAL_W-1:0] val
);

    localparam int QN = 1 << IDX_W;
    localparam int FS = 1 << (VAL_W - 1);

    logic [VAL_W-1:0] tbl [QN];

    for (genvar i = 0; i < QN; i++) begin : g_ent
        localparam longint EV = ssm_pkg::quarter_val(SHAPE, longint'(i),
                                                     longint'(QN), longint'(FS));
        assign tbl[i] = VAL_W'(EV);
    end

    // Pick the table entry, or full scale at the quarter end point.
    always_comb begin
        val = k[IDX_W] ? VAL_W'(FS - 1) : tbl[k[IDX_W-1:0]];
    end

endmodule

// File: rtl/ssm_profile_shaper.sv
// Maps a sweep phase to a signed normalized profile value by mirroring a
// quarter-wave magnitude across four quadrants. Purely combinational.
module ssm_profile_shaper #(
    parameter int PH_W  = 8,
    parameter int OUT_W = 16
) (
    input  logic [PH_W-1:0]         phase,
    input  logic [1:0]              shape_sel,
    output logic signed [OUT_W-1:0] prof
);
    import ssm_pkg::*;

    localparam int IDX_W = PH_W - 2;
    localparam int QN    = 1 << IDX_W;

    logic [1:0]       quad;
    logic [IDX_W:0]   kk;
    logic [OUT_W-1:0] mag_by_shape [SHAPE_COUNT];
    logic [OUT_W-1:0] mag;

    assign quad = phase[PH_W-1 -: 2];

    // Odd quadrants run the quarter table backwards.
    always_comb begin
        kk = quad[0] ? ((IDX_W + 1)'(QN) - {1'b0, phase[IDX_W-1:0]})
                     : {1'b0, phase[IDX_W-1:0]};
    end

    for (genvar s = 0; s < SHAPE_COUNT; s++) begin : g_shape
        ssm_quarter_rom #(
            .SHAPE(s),
            .IDX_W(IDX_W),
            .VAL_W(OUT_W)
        ) u_rom (
            .k  (kk),
            .val(mag_by_shape[s])
        );
    end

    // Choose the magnitude for the selected shape.
    always_comb begin
        case (shape_e'(shape_sel))
            SHP_SINE:  mag = mag_by_shape[1];
            SHP_STEEP: mag = mag_by_shape[2];
            default:   mag = mag_by_shape[0];
        endcase
    end

    // Upper two quadrants are negative.
    always_comb begin
        prof = quad[1] ? -$signed(mag) : $signed(mag);
    end

endmodule

// File: rtl/ssm_scaler.sv
// Scales a normalized profile (full scale 2^(OUT_W-1)) by the deviation
// word. Center: p*dev/2^OUT_W. Down: (p - full scale)*dev/2^OUT_W. Results
// floor toward minus infinity. Assumes dev fits in OUT_W-1 bits.
module ssm_scaler #(
    parameter int OUT_W = 16,
    parameter int DEV_W = OUT_W - 1
) (
    input  logic signed [OUT_W-1:0] prof,
    input  logic                    down,
    input  logic [DEV_W-1:0]        dev,
    output logic signed [OUT_W-1:0] off
);

    localparam int BW = OUT_W + 2;
    localparam int PW = 2 * BW;

    logic signed [BW-1:0] base;
    logic signed [BW-1:0] dev_s;
    logic signed [PW-1:0] prod;

    // Shift the profile down by full scale in down mode, then multiply.
    always_comb begin
        base = {{2{prof[OUT_W-1]}}, prof};
        if (down) base = base - $signed({3'b001, {(OUT_W - 1){1'b0}}});
        dev_s = $signed({{(BW - DEV_W){1'b0}}, dev});
        prod  = base * dev_s;
        off   = OUT_W'(prod >>> OUT_W);
    end

endmodule

// File: rtl/ssm_profile_gen.sv
// Spread-spectrum modulation profile generator, top level. Latches the
// configuration at sweep wrap, feeds phase through shaper and scaler, and
// registers the offset, mean and update pulse. Synchronous active-low reset.
module ssm_profile_gen #(
    parameter int OUT_W = 16,
    parameter int PH_W  = 8,
    parameter int DIV_W = 16,
    localparam int DEV_W = OUT_W - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spread_en,
    input  logic                    down_sel,
    input  logic [1:0]              shape_sel,
    input  logic [DEV_W-1:0]        dev_cfg,
    input  logic [DIV_W-1:0]        rate_div,
    output logic signed [OUT_W-1:0] offset_out,
    output logic signed [OUT_W-1:0] mean_out,
    output logic                    upd_tick
);

    localparam logic signed [OUT_W-1:0] ONE_S = OUT_W'(1);

    logic             act_down;
    logic [1:0]       act_shape;
    logic [DEV_W-1:0] act_dev;
    logic [DIV_W-1:0] act_div;

    logic             tick, wrap;
    logic [PH_W-1:0]  phase;
    logic signed [OUT_W-1:0] prof, off_next;
    logic             tick_q;

    // Adopt configuration while idle or at the sweep wrap only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_down  <= 1'b0;
            act_shape <= '0;
            act_dev   <= '0;
            act_div   <= '0;
        end else if (!spread_en || wrap) begin
            act_down  <= down_sel;
            act_shape <= shape_sel;
            act_dev   <= dev_cfg;
            act_div   <= rate_div;
        end
    end

    ssm_phase_gen #(.PH_W(PH_W), .DIV_W(DIV_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (spread_en),
        .div_val(act_div),
        .tick   (tick),
        .wrap   (wrap),
        .phase  (phase)
    );

    ssm_profile_shaper #(.PH_W(PH_W), .OUT_W(OUT_W)) u_shape (
        .phase    (phase),
        .shape_sel(act_shape),
        .prof     (prof)
    );

    ssm_scaler #(.OUT_W(OUT_W), .DEV_W(DEV_W)) u_scale (
        .prof(prof),
        .down(act_down),
        .dev (act_dev),
        .off (off_next)
    );

    // Register the offset and mean; zero them when spreading is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !spread_en) begin
            offset_out <= '0;
            mean_out   <= '0;
        end else begin
            offset_out <= off_next;
            mean_out   <= act_down ? -$signed({2'b00, act_dev[DEV_W-1:1]}) : '0;
        end
    end

    // Delay the step pulse to line up with the first cycle of the new offset.
    always_ff @(posedge clk) begin
        if (!rst_n || !spread_en) begin
            tick_q   <= 1'b0;
            upd_tick <= 1'b0;
        end else begin
            tick_q   <= tick;
            upd_tick <= tick_q;
        end
    end

    // R2: disabling gives a clean zero output on the next edge.
    assert_disabled_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !spread_en |=> (offset_out == '0 && mean_out == '0 && !upd_tick));

    // R9: down spreading never produces a positive offset.
    assert_down_nonpos_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (spread_en && act_down) |=> (offset_out[OUT_W-1] || offset_out == '0));

    // R8: center spreading stays within half the deviation either side.
    assert_center_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (spread_en && !act_down) |=>
            ((offset_out <= $signed({2'b00, $past(act_dev[DEV_W-1:1])})) &&
             (offset_out >= -$signed({2'b00, $past(act_dev[DEV_W-1:1])}) - ONE_S)));

    // R11: configuration holds steady inside a running sweep.
    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (spread_en && !wrap) |=> ($stable(act_down) && $stable(act_shape) &&
                                  $stable(act_dev) && $stable(act_div)));

endmodule

// File: tb/ssm_profile_gen_test.sv
module ssm_profile_gen_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        spread_en;
    logic        down_sel;
    logic [1:0]  shape_sel;
    logic [14:0] dev_cfg;
    logic [15:0] rate_div;
    logic signed [15:0] offset_out, mean_out;
    logic        upd_tick;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    ssm_profile_gen uut (
        .clk(clk), .rst_n(rst_n), .spread_en(spread_en), .down_sel(down_sel),
        .shape_sel(shape_sel), .dev_cfg(dev_cfg), .rate_div(rate_div),
        .offset_out(offset_out), .mean_out(mean_out), .upd_tick(upd_tick)
    );

    // Vector table: mode, shape, deviation, step length, expected mean.
    localparam int NV = 8;
    localparam int V_DOWN  [NV] = '{0, 1, 0, 1, 0, 1, 0, 1};
    localparam int V_SHAPE [NV] = '{0, 0, 1, 1, 2, 2, 3, 0};
    localparam int V_DEV   [NV] = '{1000, 1000, 20000, 32767, 5001, 12345, 32767, 0};
    localparam int V_DIV   [NV] = '{1, 2, 1, 1, 3, 1, 0, 1};
    localparam int V_MEAN  [NV] = '{0, -500, 0, -16383, 0, -6172, 0, 0};

    function automatic int qv(input int shape, input int k);
        int v;
        case (shape)
            1:       v = (12288 * k - k * k * k) / 16;
            2:       v = (4096 * k + k * k * k) / 16;
            default: v = 512 * k;
        endcase
        return (v > 32767) ? 32767 : v;
    endfunction

    function automatic int exp_off(input int ph, input int dn, input int shape, input int dev);
        int q, k, m;
        longint b;
        q = ph / 64;
        k = ph % 64;
        m = qv(shape, (q % 2 == 1) ? 64 - k : k);
        b = (q >= 2) ? -m : m;
        if (dn != 0) b = b - 32768;
        return int'((b * dev) >>> 16);
    endfunction

    function automatic string tag_of(input int dn, input int shape);
        string s;
        s = (shape == 1) ? "R5" : (shape == 2) ? "R6" : "R4";
        return {s, "/R7/", (dn != 0) ? "R9" : "R8"};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // Load a config while idle, enable, and compare every cycle. At sample
    // chg_at the inputs switch to the n_* config (R11 timing applies).
    task automatic walk(input int dn, input int shape, input int dev, input int dv,
                        input int ncyc, input int chg_at,
                        input int n_dn, input int n_shape, input int n_dev);
        int d, ph, cd, cs, cv, em;
        bit newcfg;
        spread_en = 1'b0;
        down_sel  = dn[0];
        shape_sel = shape[1:0];
        dev_cfg   = dev[14:0];
        rate_div  = dv[15:0];
        @(negedge clk);
        spread_en = 1'b1;
        @(negedge clk);
        d = (dv == 0) ? 1 : dv;
        for (int cyc = 0; cyc < ncyc; cyc++) begin
            newcfg = (chg_at >= 0) && (chg_at <= 256 * d - 2) && (cyc >= 256 * d);
            cd = newcfg ? n_dn : dn;
            cs = newcfg ? n_shape : shape;
            cv = newcfg ? n_dev : dev;
            ph = (cyc / d) % 256;
            em = (cd != 0) ? -(cv / 2) : 0;
            check(offset_out == exp_off(ph, cd, cs, cv), tag_of(cd, cs),
                  offset_out, exp_off(ph, cd, cs, cv));
            check(upd_tick == ((cyc > 0) && (cyc % d == 0)), "R3 upd_tick",
                  int'(upd_tick), int'((cyc > 0) && (cyc % d == 0)));
            check(mean_out == em, "R10 mean_out", mean_out, em);
            if (cyc == chg_at) begin
                down_sel  = n_dn[0];
                shape_sel = n_shape[1:0];
                dev_cfg   = n_dev[14:0];
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        spread_en = 1'b1;
        down_sel = 1'b1;
        shape_sel = 2'd1;
        dev_cfg = 15'd9000;
        rate_div = 16'd1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(offset_out == 0, "R1 offset_out", offset_out, 0);
        check(mean_out == 0, "R1 mean_out", mean_out, 0);
        check(upd_tick == 1'b0, "R1 upd_tick", int'(upd_tick), 0);
        rst_n = 1'b1;

        // Table walk over shapes, modes, deviations and step lengths.
        for (int v = 0; v < NV; v++) begin
            walk(V_DOWN[v], V_SHAPE[v], V_DEV[v], V_DIV[v], 1, -1, 0, 0, 0);
            check(mean_out == V_MEAN[v], "R10 mean table", mean_out, V_MEAN[v]);
            walk(V_DOWN[v], V_SHAPE[v], V_DEV[v], V_DIV[v],
                 256 * ((V_DIV[v] == 0) ? 1 : V_DIV[v]) + 4, -1, 0, 0, 0);
        end

        // R11: mid-sweep change waits for the wrap.
        walk(0, 0, 8000, 1, 600, 100, 1, 2, 3000);
        // R11: change one cycle before the wrap edge is still adopted.
        walk(1, 1, 4000, 1, 300, 254, 0, 0, 10000);
        // R11: change after the wrap waits a whole period.
        walk(0, 2, 6000, 1, 300, 255, 1, 0, 2000);

        // R2: drop the enable mid-sweep; zero at once and held.
        walk(1, 0, 16000, 1, 70, -1, 0, 0, 0);
        spread_en = 1'b0;
        dev_cfg = 15'd7777;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(offset_out == 0, "R2 offset while disabled", offset_out, 0);
            check(mean_out == 0, "R2 mean while disabled", mean_out, 0);
            check(upd_tick == 1'b0, "R2 upd while disabled", int'(upd_tick), 0);
        end
        // R2: re-enable restarts at phase 0 with the idle-time config.
        spread_en = 1'b1;
        @(negedge clk);
        check(offset_out == exp_off(0, 1, 0, 7777), "R2 restart phase 0",
              offset_out, exp_off(0, 1, 0, 7777));

        // R1: reset in the middle of a sweep.
        rst_n = 1'b0;
        @(negedge clk);
        check(offset_out == 0 && mean_out == 0 && !upd_tick, "R1 mid-run reset",
              offset_out, 0);
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule